// File: doc/BRIEF.md
# Frame Writeback Controller

This block captures a single frame from a streaming pixel source and stores it in memory in raster order. Software programs a destination base address, a line pitch in bytes and the frame dimensions through a small register port, then sets a start bit. The controller then takes exactly width × height pixels over a valid/ready handshake. Each pixel is one memory word. For each one it issues a write request whose address is the base plus the line index times the pitch plus four bytes per column.

A control/status word reports busy and holds the idle interrupt enable and a power-down bit. Its upper bits return a fixed identification value. A progress register counts the lines whose last word memory has accepted. A debug abort ends a frame at once and stops any further writes. The interrupt output is raised when a frame ends while the enable is set, and it drops when software writes the enable back to 0.

Top module: `fwb_writeback`

## Requirements
- R1: After reset the control word at offset 0x0C reads 0x5440_0000: identification 0x54 in bits 31:24 and 0x1 in bits 23:22, with busy (bit 1) clear. The progress register reads 0, and irq, memReq and pixReady are low.
- R2: Offsets 0x00 (base address), 0x04 (pitch) and 0x08 (dimensions, height in bits 31:16 and width in bits 15:0) read back the last value written to them.
- R3: A control write with bit 0 set and bit 21 clear, made while idle, sets busy from the next cycle. Bit 0 always reads as 0.
- R4: A frame accepts exactly width × height pixels. pixReady is low while idle, after the last pixel of the frame, and while a write request waits on memReady.
- R5: The k-th accepted pixel is written with memData equal to that pixel, at memAddr = base + (k / width) × pitch + 4 × (k mod width).
- R6: While memReq is high and memReady low, memReq, memAddr and memData hold steady.
- R7: Progress is cleared at start and increases by one each time the last word of a line is accepted by memory.
- R8: Busy clears in the cycle after memory accepts the last word of a frame. irq is high when enable bit 2 is set and a frame has ended (by completion or abort) since the last start. Writing bit 2 as 0 drops irq.
- R9: A control write with bit 14 set while busy clears busy and memReq in the next cycle, and the block makes no further pixel accepts or memory writes.
- R10: A start written while busy is ignored. Writes to base, pitch or dimensions during a frame do not change the addresses or length of that frame.
- R11: Bit 21 is stored and read back. A start written with bit 21 set is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 5 | Register byte offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr (combinational) |
| pixValid | input | 1 | Pixel offered |
| pixReady | output | 1 | Pixel taken when high with pixValid |
| pixData | input | DATA_W | Pixel word |
| memReq | output | 1 | Memory write request |
| memReady | input | 1 | Memory accepts the request this cycle |
| memAddr | output | ADDR_W | Byte address of the write |
| memData | output | DATA_W | Word to write |
| irq | output | 1 | Frame-ended interrupt |

## Verification
The assertions assume that software programs a base address with its two low bits clear and a nonzero width and height, and that memory eventually raises memReady. The bench keeps to this by drawing bases from 16-byte aligned values, widths from 1 to 8 and heights from 1 to 5, and by giving memReady a nonzero acceptance chance in every frame. The random valid and ready rates vary from frame to frame, so both back-pressure on the memory side and gaps on the pixel side occur, along with full-rate runs.

// File: rtl/fwb_pkg.sv
package fwb_pkg;
  localparam int REG_AW = 5;
  localparam logic [REG_AW-1:0] OFS_PTR   = 5'h00;
  localparam logic [REG_AW-1:0] OFS_PITCH = 5'h04;
  localparam logic [REG_AW-1:0] OFS_DIM   = 5'h08;
  localparam logic [REG_AW-1:0] OFS_CTRL  = 5'h0C;
  localparam logic [REG_AW-1:0] OFS_PROG  = 5'h10;

  localparam int BIT_GO    = 0;
  localparam int BIT_BUSY  = 1;
  localparam int BIT_IRQEN = 2;
  localparam int BIT_ABORT = 14;
  localparam int BIT_PDN   = 21;
  localparam int HEIGHT_LSB = 16;
  localparam logic [31:0] CTRL_ID = 32'h5440_0000;

  typedef struct packed {
    logic start;
    logic accept;
    logic lastCol;
    logic lastFrame;
    logic abort;
  } fwbStrobe_t;
endpackage

// File: rtl/fwb_ctrl.sv
module fwb_ctrl
  import fwb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DIM_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              pixValid,
  output logic              pixReady,
  input  logic              slotOpen,
  input  logic              commitLine,
  input  logic              commitFrame,
  output fwbStrobe_t        strobe,
  output logic [ADDR_W-1:0] cfgBase,
  output logic [ADDR_W-1:0] cfgPitch,
  output logic              irq
);
  logic [31:0] ptrReg, pitchReg, dimReg;
  logic irqEnQ, pdnQ, busyQ, endedQ, allIn;
  logic [DIM_W-1:0] colCnt, rowCnt, actW, actH, progress;
  logic ctrlWrite, startReq, abortReq, accept, lastCol, lastFrame;

  assign ctrlWrite = regWrEn && (regAddr == OFS_CTRL);
  assign startReq  = ctrlWrite && regWrData[BIT_GO] && !regWrData[BIT_PDN] && !busyQ;
  assign abortReq  = ctrlWrite && regWrData[BIT_ABORT] && busyQ;
  assign pixReady  = busyQ && !allIn && slotOpen;
  assign accept    = pixValid && pixReady;
  assign lastCol   = (colCnt == actW - 1'b1);
  assign lastFrame = lastCol && (rowCnt == actH - 1'b1);

  assign strobe = '{start: startReq, accept: accept, lastCol: lastCol,
                    lastFrame: lastFrame, abort: abortReq};
  assign cfgBase  = ptrReg[ADDR_W-1:0];
  assign cfgPitch = pitchReg[ADDR_W-1:0];
  assign irq      = irqEnQ && endedQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrReg <= '0; pitchReg <= '0; dimReg <= '0;
      irqEnQ <= 1'b0; pdnQ <= 1'b0; busyQ <= 1'b0; endedQ <= 1'b0; allIn <= 1'b0;
      colCnt <= '0; rowCnt <= '0; actW <= '0; actH <= '0; progress <= '0;
    end else begin
      if (regWrEn && regAddr == OFS_PTR)   ptrReg   <= regWrData;
      if (regWrEn && regAddr == OFS_PITCH) pitchReg <= regWrData;
      if (regWrEn && regAddr == OFS_DIM)   dimReg   <= regWrData;
      if (ctrlWrite) begin
        irqEnQ <= regWrData[BIT_IRQEN];
        pdnQ   <= regWrData[BIT_PDN];
      end
      if (startReq) begin
        busyQ <= 1'b1; endedQ <= 1'b0; allIn <= 1'b0;
        colCnt <= '0; rowCnt <= '0; progress <= '0;
        actW <= dimReg[DIM_W-1:0];
        actH <= dimReg[HEIGHT_LSB +: DIM_W];
      end else if (busyQ) begin
        if (abortReq) begin
          busyQ <= 1'b0; endedQ <= 1'b1;
        end else begin
          if (accept) begin
            if (lastCol) begin
              colCnt <= '0;
              rowCnt <= rowCnt + 1'b1;
            end else begin
              colCnt <= colCnt + 1'b1;
            end
            if (lastFrame) allIn <= 1'b1;
          end
          if (commitLine) progress <= progress + 1'b1;
          if (commitFrame) begin
            busyQ <= 1'b0; endedQ <= 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      OFS_PTR:   regRdData = ptrReg;
      OFS_PITCH: regRdData = pitchReg;
      OFS_DIM:   regRdData = dimReg;
      OFS_CTRL: begin
        regRdData = CTRL_ID;
        regRdData[BIT_PDN]   = pdnQ;
        regRdData[BIT_IRQEN] = irqEnQ;
        regRdData[BIT_BUSY]  = busyQ;
      end
      OFS_PROG:  regRdData = {{(32-DIM_W){1'b0}}, progress};
      default:   regRdData = '0;
    endcase
  end

  a_r4_idle_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    !busyQ |-> !pixReady);
  a_r9_abort_stops: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |=> (!busyQ && !pixReady));
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && ctrlWrite && regWrData[BIT_GO] && !regWrData[BIT_ABORT] && !commitFrame) |=> busyQ);
  a_r8_irq_only_idle: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> !busyQ);
  a_r7_progress_bound: assert property (@(posedge clk) disable iff (!rstN)
    progress <= actH);
endmodule

// File: rtl/fwb_datapath.sv
module fwb_datapath
  import fwb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  fwbStrobe_t        strobe,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [ADDR_W-1:0] cfgPitch,
  input  logic [DATA_W-1:0] pixData,
  input  logic              memReady,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              slotOpen,
  output logic              commitLine,
  output logic              commitFrame
);
  localparam int BYTES = DATA_W / 8;

  logic [ADDR_W-1:0] lineBase, colOff, pitchAct;
  logic tagLine, tagFrame, commit;

  assign slotOpen    = !memReq || memReady;
  assign commit      = memReq && memReady;
  assign commitLine  = commit && tagLine;
  assign commitFrame = commit && tagFrame;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memReq <= 1'b0; memAddr <= '0; memData <= '0;
      lineBase <= '0; colOff <= '0; pitchAct <= '0;
      tagLine <= 1'b0; tagFrame <= 1'b0;
    end else if (strobe.abort) begin
      memReq <= 1'b0;
    end else begin
      if (strobe.start) begin
        lineBase <= cfgBase;
        pitchAct <= cfgPitch;
        colOff   <= '0;
      end
      if (strobe.accept) begin
        memReq   <= 1'b1;
        memAddr  <= lineBase + colOff;
        memData  <= pixData;
        tagLine  <= strobe.lastCol;
        tagFrame <= strobe.lastFrame;
        if (strobe.lastCol) begin
          lineBase <= lineBase + pitchAct;
          colOff   <= '0;
        end else begin
          colOff <= colOff + ADDR_W'(BYTES);
        end
      end else if (commit) begin
        memReq <= 1'b0;
      end
    end
  end

  a_r6_hold_stalled: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady && !strobe.abort) |=> (memReq && $stable(memAddr) && $stable(memData)));
  a_r5_word_aligned: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[1:0] == 2'b00));
endmodule

// File: rtl/fwb_writeback.sv
module fwb_writeback
  import fwb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DIM_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [4:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              pixValid,
  output logic              pixReady,
  input  logic [DATA_W-1:0] pixData,
  output logic              memReq,
  input  logic              memReady,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              irq
);
  fwbStrobe_t strobe;
  logic [ADDR_W-1:0] cfgBase, cfgPitch;
  logic slotOpen, commitLine, commitFrame;

  fwb_ctrl #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .pixValid(pixValid),
    .pixReady(pixReady), .slotOpen(slotOpen), .commitLine(commitLine),
    .commitFrame(commitFrame), .strobe(strobe), .cfgBase(cfgBase),
    .cfgPitch(cfgPitch), .irq(irq)
  );

  fwb_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgBase(cfgBase),
    .cfgPitch(cfgPitch), .pixData(pixData), .memReady(memReady),
    .memReq(memReq), .memAddr(memAddr), .memData(memData),
    .slotOpen(slotOpen), .commitLine(commitLine), .commitFrame(commitFrame)
  );
endmodule

// File: tb/sim_fwb_writeback.sv
module sim_fwb_writeback;
  localparam logic [4:0] A_PTR = 5'h00, A_PITCH = 5'h04, A_DIM = 5'h08,
                         A_CTRL = 5'h0C, A_PROG = 5'h10;

  logic clk = 1'b0, rstN = 1'b0, regWrEn = 1'b0, pixValid = 1'b0, memReady = 1'b0;
  logic [4:0] regAddr = '0;
  logic [31:0] regWrData = '0, regRdData, pixData = '0, memAddr, memData;
  logic pixReady, memReq, irq;

  int checks = 0, failures = 0, cyc = 0;
  int accCnt, commitIdx, curW = 1, curTotal;
  logic [31:0] curBase, curPitch;
  logic [31:0] expData [0:63];
  bit holdPrev;
  logic [31:0] prevAddr, prevData;

  fwb_writeback u0 (.*);

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expAddr(input int k);
    return curBase + (k / curW) * curPitch + 4 * (k % curW);
  endfunction

  task automatic regWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    pixValid = 1'b0; memReady = 1'b0;
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    regAddr = a;
    #1;
    v = regRdData;
  endtask

  task automatic step(input bit feed, input int vPct, input int rPct);
    @(negedge clk);
    pixValid = feed && (($urandom % 100) < vPct);
    pixData  = $urandom;
    memReady = (($urandom % 100) < rPct);
    regAddr  = A_PROG;
    #1;
    chk(regRdData == 32'(commitIdx / curW), "R7 progress", regRdData, 32'(commitIdx / curW));
    if (accCnt == curTotal) chk(!pixReady, "R4 ready after last pixel", {31'b0, pixReady}, 32'd0);
    if (holdPrev)
      chk(memReq && memAddr == prevAddr && memData == prevData, "R6 stalled hold", memAddr, prevAddr);
    if (pixValid && pixReady) begin
      expData[accCnt] = pixData;
      accCnt++;
    end
    if (memReq && memReady) begin
      chk(memAddr == expAddr(commitIdx), "R5 address", memAddr, expAddr(commitIdx));
      chk(memData == expData[commitIdx], "R5 data", memData, expData[commitIdx]);
      commitIdx++;
    end
    holdPrev = memReq && !memReady;
    prevAddr = memAddr; prevData = memData;
  endtask

  task automatic runFrame(input logic [31:0] base, input logic [31:0] pitch, input int w,
                          input int h, input bit ei, input bit midWrite, input int vPct, input int rPct);
    logic [31:0] v;
    int guard;
    curBase = base; curPitch = pitch; curW = w; curTotal = w * h;
    accCnt = 0; commitIdx = 0; holdPrev = 1'b0;
    regWrite(A_PTR, base);
    regWrite(A_PITCH, pitch);
    regWrite(A_DIM, {16'(h), 16'(w)});
    rd(A_DIM, v);
    chk(v == {16'(h), 16'(w)}, "R2 dim readback", v, {16'(h), 16'(w)});
    rd(A_PITCH, v);
    chk(v == pitch, "R2 pitch readback", v, pitch);
    regWrite(A_CTRL, 32'h1 | (32'(ei) << 2));
    rd(A_CTRL, v);
    chk(v[1] == 1'b1 && v[0] == 1'b0, "R3 busy after start", v, 32'h5440_0002 | (32'(ei) << 2));
    if (midWrite) begin
      regWrite(A_PTR, base ^ 32'h0000_1000);
      regWrite(A_DIM, 32'h0002_0002);
      regWrite(A_CTRL, 32'h1 | (32'(ei) << 2));
      rd(A_CTRL, v);
      chk(v[1] == 1'b1, "R10 start while busy keeps busy", v, 32'h5440_0002);
    end
    guard = 0;
    while (commitIdx < curTotal && guard < 2000) begin
      step(1'b1, vPct, rPct);
      guard++;
    end
    chk(commitIdx == curTotal, "R4 word count", 32'(commitIdx), 32'(curTotal));
    chk(accCnt == curTotal, "R4 pixel count", 32'(accCnt), 32'(curTotal));
    @(negedge clk);
    pixValid = 1'b1; memReady = 1'b1;
    rd(A_CTRL, v);
    chk(v == (32'h5440_0000 | (32'(ei) << 2)), "R8 idle after frame", v, 32'h5440_0000 | (32'(ei) << 2));
    chk(irq == ei, "R8 irq after frame", {31'b0, irq}, {31'b0, ei});
    chk(!pixReady && !memReq, "R4 no accept after frame", {30'b0, pixReady, memReq}, 32'd0);
    rd(A_PROG, v);
    chk(v == 32'(h), "R7 final progress", v, 32'(h));
    if (midWrite) begin
      rd(A_PTR, v);
      chk(v == (base ^ 32'h0000_1000), "R10 mid-frame ptr write kept for later", v, base ^ 32'h0000_1000);
    end
    pixValid = 1'b0;
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    rd(A_CTRL, v);
    chk(v == 32'h5440_0000, "R1 control reset value", v, 32'h5440_0000);
    rd(A_PROG, v);
    chk(v == 32'd0, "R1 progress reset", v, 32'd0);
    pixValid = 1'b1; #1;
    chk(!irq && !memReq && !pixReady, "R1 outputs idle", {29'b0, irq, memReq, pixReady}, 32'd0);
    pixValid = 1'b0;

    runFrame(32'h0000_4000, 32'd16, 1, 1, 1'b1, 1'b0, 100, 100);
    runFrame(32'h0001_0000, 32'd32, 8, 1, 1'b0, 1'b0, 100, 30);
    runFrame(32'h0002_0010, 32'd16, 1, 4, 1'b1, 1'b0, 40, 100);
    runFrame(32'h0003_0000, 32'd48, 5, 3, 1'b1, 1'b1, 70, 50);
    for (int i = 0; i < 6; i++) begin
      int w, h;
      logic [31:0] p;
      w = 1 + ($urandom % 8);
      h = 1 + ($urandom % 5);
      p = ((32'(w) * 4 + 15) & ~32'd15) + 16 * ($urandom % 3);
      runFrame(($urandom & 32'h00FF_FFF0), p, w, h, 1'($urandom), 1'($urandom), 20 + ($urandom % 81), 20 + ($urandom % 81));
    end

    curBase = 32'h0008_0000; curPitch = 32'd32; curW = 4; curTotal = 12;
    accCnt = 0; commitIdx = 0; holdPrev = 1'b0;
    regWrite(A_PTR, curBase);
    regWrite(A_PITCH, curPitch);
    regWrite(A_DIM, {16'd3, 16'd4});
    regWrite(A_CTRL, 32'h0000_0005);
    while (commitIdx < 5) step(1'b1, 100, 100);
    regWrite(A_CTRL, 32'h0000_4004);
    rd(A_CTRL, v);
    chk(v == 32'h5440_0004, "R9 busy cleared by abort", v, 32'h5440_0004);
    chk(!memReq, "R9 request dropped", {31'b0, memReq}, 32'd0);
    chk(irq, "R8 irq after abort", {31'b0, irq}, 32'd1);
    rd(A_PROG, v);
    chk(v == 32'd1, "R9 progress kept at abort", v, 32'd1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      pixValid = 1'b1; memReady = 1'b1;
      #1;
      chk(!pixReady && !memReq, "R9 nothing after abort", {30'b0, pixReady, memReq}, 32'd0);
    end
    regWrite(A_CTRL, 32'h0);
    #1;
    chk(!irq, "R8 irq cleared by enable write", {31'b0, irq}, 32'd0);

    regWrite(A_CTRL, 32'h0020_0001);
    rd(A_CTRL, v);
    chk(v == 32'h5460_0000, "R11 power-down start ignored", v, 32'h5460_0000);
    pixValid = 1'b1; #1;
    chk(!pixReady, "R11 no accept when powered down", {31'b0, pixReady}, 32'd0);
    regWrite(A_CTRL, 32'h0);
    rd(A_CTRL, v);
    chk(v == 32'h5440_0000, "R11 power-down cleared", v, 32'h5440_0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule